// File: doc/BRIEF.md
# File-Register ALU Execute Unit

This block is the execute stage of a small accumulator-style processor. Each accepted 14-bit word names an operation, and the block applies it to a working register W and to an internal store of 128 eight-bit file registers. The block holds three status flags: zero (Z), carry (C) and digit carry (DC). It has three groups of operations. Byte operations combine a file register with W and use a single destination bit to choose where the result goes. Bit operations clear, set or test one bit of a file register. Literal operations combine W with an 8-bit constant taken from the word.

Some operations ask the surrounding pipeline to discard the next word. The block reports this on a registered skip request. Instruction fetch, the program counter, calls and jumps, banking and indirect addressing are handled outside. Words from those groups, and undefined words, leave the state unchanged.

Top module: `fru_exec_top`

## Requirements
- R1: In a byte-oriented word, bits 13:8 hold the opcode, bit 7 is the destination select and bits 6:0 are the file address. With the destination at 0 only W takes the result. With it at 1 only the addressed entry takes the result. Every address from 0x00 to 0x7F is reachable.
- R2: While reset is low, and after it is released, W, Z, C, DC and the skip request are all 0, and every file entry reads back as 0x00.
- R3: Opcode 000001 writes 0x00 to W (destination 0) or to the file entry (destination 1), and sets Z. Opcode 000000 with destination 1 copies W into the file entry and leaves all flags as they were. Opcode 000000 with destination 0 changes nothing.
- R4: Increment (001010) and decrement (000011) wrap: 0xFF+1 gives 0x00 with Z=1, and 0x00-1 gives 0xFF with Z=0. Only Z is updated.
- R5: File subtract (000010) computes f-W, and literal subtract (bits 13:8 = 11110x) computes k-W, both in two's complement. C=1 means no borrow out of bit 7, DC=1 means no borrow out of bit 3, and Z reflects the result.
- R6: File add (000111) and literal add (11111x) form W plus the operand. C and DC are the carries out of bits 7 and 3, and Z reflects the result.
- R7: Each of the following updates Z only: AND (000101 / literal 111001), inclusive OR (000100 / 111000), exclusive OR (000110 / 111010), complement (001001) and file move (001000). Literal load (1100xx) writes k to W and changes no flag.
- R8: A bit-oriented word has bits 13:12 = 01. Bits 11:10 give the action: 00 clear, 01 set, 10 test-skip-if-clear, 11 test-skip-if-set. Bits 9:7 give the bit index and bits 6:0 the address. Clear and set change only the selected bit and leave all flags unchanged.
- R9: Test-skip-if-clear raises the skip request when the tested bit is 0. Test-skip-if-set raises it when the bit is 1. Neither writes anything.
- R10: Increment-and-skip (001111) and decrement-and-skip (001011) write their result per the destination bit. They raise the skip request only when the result is 0x00, and change no flag.
- R11: Rotate right (001100) and rotate left (001101) shift through C, and the bit shifted out becomes the new C. Only C is updated. Nibble swap (001110) exchanges the two 4-bit halves and changes no flag.
- R12: Results, flags and the skip request appear in the cycle after the word is accepted. When instrValid is low, no register or flag changes and the skip request is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| instrValid | input | 1 | The word on instr is executed at this edge |
| instr | input | 14 | Instruction word |
| wOut | output | 8 | Working register W |
| zFlag | output | 1 | Zero flag |
| cFlag | output | 1 | Carry / not-borrow flag |
| dcFlag | output | 1 | Digit carry / not-borrow from bit 3 |
| skipReq | output | 1 | Discard the following word |

## Verification
The bench checks the borrow sense of subtraction in both directions: 0x5A-0x69 must leave C clear and DC set, and 0x00-0x01 must clear both. A design that took C as a raw borrow, or took DC from the wrong nibble, fails there. Wrapping is checked at 0xFF and 0x00 for increment and decrement, and on the skip forms. A skip that used the operand instead of the result, or that touched Z, would be caught. The bench also issues a clear-file word with instrValid low and then reads the entry back. It runs one operation with each destination value and reads the other location back, which catches a destination bit that is inverted or that writes both places.

// File: rtl/fru_pkg.sv
package fru_pkg;

  typedef enum logic [3:0] {
    ALU_PASS_A, ALU_PASS_W, ALU_ZERO, ALU_ADD,
    ALU_SUB,    ALU_AND,    ALU_IOR,  ALU_XOR,
    ALU_COM,    ALU_INC,    ALU_DEC,  ALU_RRC,
    ALU_RLC,    ALU_SWAP,   ALU_BCLR, ALU_BSET
  } aluOpE;

  typedef struct packed {
    aluOpE aluOp;
    logic  useLit;
    logic  writeW;
    logic  writeF;
    logic  updZ;
    logic  updC;
    logic  updDC;
    logic  skipZero;
    logic  skipBitClr;
    logic  skipBitSet;
  } ctrlStrobeT;

endpackage

// File: rtl/fru_ctrl.sv
module fru_ctrl
  import fru_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  localparam int BIT_W   = $clog2(DATA_W),
  localparam int INSTR_W = ADDR_W + 7
) (
  input  logic [INSTR_W-1:0] instr,
  output ctrlStrobeT         strb,
  output logic [ADDR_W-1:0]  fAddr,
  output logic [BIT_W-1:0]   bitSel,
  output logic [DATA_W-1:0]  lit
);

  logic [1:0] grp;
  logic [3:0] sub;
  logic       dest;

  assign grp    = instr[INSTR_W-1 -: 2];
  assign sub    = instr[INSTR_W-3 -: 4];
  assign dest   = instr[ADDR_W];
  assign fAddr  = instr[ADDR_W-1:0];
  assign bitSel = instr[ADDR_W +: BIT_W];
  assign lit    = instr[DATA_W-1:0];

  always_comb begin
    strb       = '0;
    strb.aluOp = ALU_PASS_A;
    unique case (grp)
      2'b00: begin
        strb.writeW = ~dest;
        strb.writeF = dest;
        strb.updZ   = 1'b1;
        unique case (sub)
          4'h0: begin
            strb.aluOp  = ALU_PASS_W;
            strb.writeW = 1'b0;
            strb.updZ   = 1'b0;
          end
          4'h1: strb.aluOp = ALU_ZERO;
          4'h2: begin
            strb.aluOp = ALU_SUB;
            strb.updC  = 1'b1;
            strb.updDC = 1'b1;
          end
          4'h3: strb.aluOp = ALU_DEC;
          4'h4: strb.aluOp = ALU_IOR;
          4'h5: strb.aluOp = ALU_AND;
          4'h6: strb.aluOp = ALU_XOR;
          4'h7: begin
            strb.aluOp = ALU_ADD;
            strb.updC  = 1'b1;
            strb.updDC = 1'b1;
          end
          4'h8: strb.aluOp = ALU_PASS_A;
          4'h9: strb.aluOp = ALU_COM;
          4'hA: strb.aluOp = ALU_INC;
          4'hB: begin
            strb.aluOp    = ALU_DEC;
            strb.updZ     = 1'b0;
            strb.skipZero = 1'b1;
          end
          4'hC: begin
            strb.aluOp = ALU_RRC;
            strb.updZ  = 1'b0;
            strb.updC  = 1'b1;
          end
          4'hD: begin
            strb.aluOp = ALU_RLC;
            strb.updZ  = 1'b0;
            strb.updC  = 1'b1;
          end
          4'hE: begin
            strb.aluOp = ALU_SWAP;
            strb.updZ  = 1'b0;
          end
          default: begin
            strb.aluOp    = ALU_INC;
            strb.updZ     = 1'b0;
            strb.skipZero = 1'b1;
          end
        endcase
      end
      2'b01: begin
        unique case (sub[3:2])
          2'b00: begin
            strb.aluOp  = ALU_BCLR;
            strb.writeF = 1'b1;
          end
          2'b01: begin
            strb.aluOp  = ALU_BSET;
            strb.writeF = 1'b1;
          end
          2'b10:   strb.skipBitClr = 1'b1;
          default: strb.skipBitSet = 1'b1;
        endcase
      end
      2'b11: begin
        strb.useLit = 1'b1;
        strb.writeW = 1'b1;
        strb.updZ   = 1'b1;
        casez (sub)
          4'b00??: begin
            strb.aluOp = ALU_PASS_A;
            strb.updZ  = 1'b0;
          end
          4'b1000: strb.aluOp = ALU_IOR;
          4'b1001: strb.aluOp = ALU_AND;
          4'b1010: strb.aluOp = ALU_XOR;
          4'b110?: begin
            strb.aluOp = ALU_SUB;
            strb.updC  = 1'b1;
            strb.updDC = 1'b1;
          end
          4'b111?: begin
            strb.aluOp = ALU_ADD;
            strb.updC  = 1'b1;
            strb.updDC = 1'b1;
          end
          default: begin
            strb.writeW = 1'b0;
            strb.updZ   = 1'b0;
          end
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fru_alu.sv
module fru_alu
  import fru_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W),
  localparam int HALF  = DATA_W / 2
) (
  input  aluOpE              aluOp,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opW,
  input  logic               carryIn,
  input  logic [BIT_W-1:0]   bitSel,
  output logic [DATA_W-1:0]  res,
  output logic               carryOut,
  output logic               digitOut
);

  logic [DATA_W:0] addFull, subFull;
  logic [HALF:0]   addLow, subLow;
  logic [DATA_W-1:0] bitMask;

  always_comb begin
    addFull = {1'b0, opA} + {1'b0, opW};
    subFull = {1'b0, opA} + {1'b0, ~opW} + {{DATA_W{1'b0}}, 1'b1};
    addLow  = {1'b0, opA[HALF-1:0]} + {1'b0, opW[HALF-1:0]};
    subLow  = {1'b0, opA[HALF-1:0]} + {1'b0, ~opW[HALF-1:0]} + {{HALF{1'b0}}, 1'b1};
    bitMask = {{(DATA_W-1){1'b0}}, 1'b1} << bitSel;
  end

  always_comb begin
    res      = opA;
    carryOut = carryIn;
    digitOut = 1'b0;
    unique case (aluOp)
      ALU_PASS_A: res = opA;
      ALU_PASS_W: res = opW;
      ALU_ZERO:   res = '0;
      ALU_ADD: begin
        res      = addFull[DATA_W-1:0];
        carryOut = addFull[DATA_W];
        digitOut = addLow[HALF];
      end
      ALU_SUB: begin
        res      = subFull[DATA_W-1:0];
        carryOut = subFull[DATA_W];
        digitOut = subLow[HALF];
      end
      ALU_AND:  res = opA & opW;
      ALU_IOR:  res = opA | opW;
      ALU_XOR:  res = opA ^ opW;
      ALU_COM:  res = ~opA;
      ALU_INC:  res = opA + DATA_W'(1);
      ALU_DEC:  res = opA - DATA_W'(1);
      ALU_RRC: begin
        res      = {carryIn, opA[DATA_W-1:1]};
        carryOut = opA[0];
      end
      ALU_RLC: begin
        res      = {opA[DATA_W-2:0], carryIn};
        carryOut = opA[DATA_W-1];
      end
      ALU_SWAP: res = {opA[HALF-1:0], opA[DATA_W-1:HALF]};
      ALU_BCLR: res = opA & ~bitMask;
      default:  res = opA | bitMask;
    endcase
  end

endmodule

// File: rtl/fru_datapath.sv
module fru_datapath
  import fru_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  localparam int BIT_W = $clog2(DATA_W),
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  ctrlStrobeT        strb,
  input  logic [ADDR_W-1:0] fAddr,
  input  logic [BIT_W-1:0]  bitSel,
  input  logic [DATA_W-1:0] lit,
  output logic [DATA_W-1:0] wReg,
  output logic              zFlag,
  output logic              cFlag,
  output logic              dcFlag,
  output logic              skipReq
);

  logic [DATA_W-1:0] fileMem [DEPTH];
  logic [DATA_W-1:0] fileRd, operand, aluRes;
  logic              aluC, aluDC, resZero, testBit, skipCond;

  assign fileRd  = fileMem[fAddr];
  assign operand = strb.useLit ? lit : fileRd;

  fru_alu #(.DATA_W(DATA_W)) uAlu (
    .aluOp   (strb.aluOp),
    .opA     (operand),
    .opW     (wReg),
    .carryIn (cFlag),
    .bitSel  (bitSel),
    .res     (aluRes),
    .carryOut(aluC),
    .digitOut(aluDC)
  );

  assign resZero  = (aluRes == '0);
  assign testBit  = operand[bitSel];
  assign skipCond = (strb.skipZero & resZero)
                  | (strb.skipBitClr & ~testBit)
                  | (strb.skipBitSet & testBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wReg    <= '0;
      zFlag   <= 1'b0;
      cFlag   <= 1'b0;
      dcFlag  <= 1'b0;
      skipReq <= 1'b0;
      for (int i = 0; i < DEPTH; i++) fileMem[i] <= '0;
    end else begin
      skipReq <= instrValid & skipCond;
      if (instrValid) begin
        if (strb.writeW) wReg <= aluRes;
        if (strb.writeF) fileMem[fAddr] <= aluRes;
        if (strb.updZ)   zFlag <= resZero;
        if (strb.updC)   cFlag <= aluC;
        if (strb.updDC)  dcFlag <= aluDC;
      end
    end
  end

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.writeW && strb.writeF)); // R1

  AST_CLEAR_SETS_Z: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && strb.aluOp == ALU_ZERO) |=> zFlag); // R3

  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && strb.aluOp == ALU_INC && strb.writeW && operand == {DATA_W{1'b1}})
      |=> (wReg == '0)); // R4

  AST_BITOP_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && (strb.aluOp == ALU_BCLR || strb.aluOp == ALU_BSET))
      |=> $stable({zFlag, cFlag, dcFlag})); // R8

  AST_SKIP_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && (strb.skipZero || strb.skipBitClr || strb.skipBitSet))
      |=> $stable({zFlag, cFlag, dcFlag})); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> ($stable(wReg) && $stable({zFlag, cFlag, dcFlag}) && !skipReq)); // R12

endmodule

// File: rtl/fru_exec_top.sv
module fru_exec_top
  import fru_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  localparam int BIT_W   = $clog2(DATA_W),
  localparam int INSTR_W = ADDR_W + 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instr,
  output logic [DATA_W-1:0]  wOut,
  output logic               zFlag,
  output logic               cFlag,
  output logic               dcFlag,
  output logic               skipReq
);

  ctrlStrobeT        strb;
  logic [ADDR_W-1:0] fAddr;
  logic [BIT_W-1:0]  bitSel;
  logic [DATA_W-1:0] lit;

  fru_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .instr (instr),
    .strb  (strb),
    .fAddr (fAddr),
    .bitSel(bitSel),
    .lit   (lit)
  );

  fru_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .instrValid(instrValid),
    .strb      (strb),
    .fAddr     (fAddr),
    .bitSel    (bitSel),
    .lit       (lit),
    .wReg      (wOut),
    .zFlag     (zFlag),
    .cFlag     (cFlag),
    .dcFlag    (dcFlag),
    .skipReq   (skipReq)
  );

  AST_SKIP_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    skipReq |-> $past(instrValid)); // R9

endmodule

// File: tb/tb_fru_exec_top.sv
`timescale 1ns/1ps
module tb_fru_exec_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [13:0] instr = '0;
  logic [7:0]  wOut;
  logic        zFlag, cFlag, dcFlag, skipReq;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  fru_exec_top dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr),
    .wOut(wOut), .zFlag(zFlag), .cFlag(cFlag), .dcFlag(dcFlag), .skipReq(skipReq)
  );

  // {instr[13:0], expected W[7:0], expected {Z,C,DC,skip}, requirement number}
  localparam int NV = 36;
  localparam logic [29:0] VEC [NV] = '{
    {6'b110000, 8'h5A,         8'h5A, 4'b0000, 4'd7},   // R7 load literal
    {6'b000000, 1'b1, 7'h10,   8'h5A, 4'b0000, 4'd3},   // R3 W to file
    {6'b110000, 8'h0F,         8'h0F, 4'b0000, 4'd7},   // R7
    {6'b000111, 1'b0, 7'h10,   8'h69, 4'b0010, 4'd6},   // R6 0x0F+0x5A
    {6'b000010, 1'b1, 7'h10,   8'h69, 4'b0010, 4'd5},   // R5 0x5A-0x69 -> file
    {6'b001000, 1'b0, 7'h10,   8'hF1, 4'b0010, 4'd1},   // R1 file now 0xF1
    {6'b111001, 8'h0E,         8'h00, 4'b1010, 4'd7},   // R7 AND to zero
    {6'b111000, 8'h81,         8'h81, 4'b0010, 4'd7},   // R7 IOR
    {6'b111010, 8'h81,         8'h00, 4'b1010, 4'd7},   // R7 XOR
    {6'b111100, 8'h03,         8'h03, 4'b0110, 4'd5},   // R5 3-0
    {6'b111110, 8'hFD,         8'h00, 4'b1110, 4'd6},   // R6 carry out
    {6'b110000, 8'h01,         8'h01, 4'b1110, 4'd7},   // R7 flags held
    {6'b111100, 8'h00,         8'hFF, 4'b0000, 4'd5},   // R5 0-1 borrows
    {6'b001001, 1'b0, 7'h10,   8'h0E, 4'b0000, 4'd7},   // R7 complement
    {6'b000001, 1'b0, 7'h00,   8'h00, 4'b1000, 4'd3},   // R3 clear W
    {6'b000001, 1'b1, 7'h10,   8'h00, 4'b1000, 4'd3},   // R3 clear file
    {6'b000011, 1'b1, 7'h10,   8'h00, 4'b0000, 4'd4},   // R4 0-1 -> 0xFF
    {6'b001010, 1'b0, 7'h10,   8'h00, 4'b1000, 4'd4},   // R4 0xFF+1 -> W
    {6'b001000, 1'b0, 7'h10,   8'hFF, 4'b0000, 4'd1},   // R1 file untouched
    {6'b001111, 1'b1, 7'h10,   8'hFF, 4'b0001, 4'd10},  // R10 wrap skip
    {6'b001111, 1'b1, 7'h10,   8'hFF, 4'b0000, 4'd10},  // R10 no skip
    {6'b001011, 1'b0, 7'h10,   8'h00, 4'b0001, 4'd10},  // R10 to W
    {6'b001011, 1'b1, 7'h10,   8'h00, 4'b0001, 4'd10},  // R10 to file
    {4'b0101, 3'd3, 7'h10,     8'h00, 4'b0000, 4'd8},   // R8 set bit 3
    {4'b0111, 3'd3, 7'h10,     8'h00, 4'b0001, 4'd9},   // R9 set -> skip
    {4'b0110, 3'd3, 7'h10,     8'h00, 4'b0000, 4'd9},   // R9
    {4'b0110, 3'd2, 7'h10,     8'h00, 4'b0001, 4'd9},   // R9 clear -> skip
    {4'b0100, 3'd3, 7'h10,     8'h00, 4'b0000, 4'd8},   // R8 clear bit 3
    {4'b0111, 3'd3, 7'h10,     8'h00, 4'b0000, 4'd9},   // R9
    {6'b110000, 8'h81,         8'h81, 4'b0000, 4'd7},   // R7
    {6'b111110, 8'h80,         8'h01, 4'b0100, 4'd6},   // R6
    {6'b000000, 1'b1, 7'h20,   8'h01, 4'b0100, 4'd3},   // R3
    {6'b001100, 1'b1, 7'h20,   8'h01, 4'b0100, 4'd11},  // R11 rotate right
    {6'b001101, 1'b0, 7'h20,   8'h01, 4'b0100, 4'd11},  // R11 rotate left
    {6'b001110, 1'b0, 7'h20,   8'h08, 4'b0100, 4'd11},  // R11 swap
    {6'b001000, 1'b1, 7'h20,   8'h08, 4'b0100, 4'd1}    // R1 move onto itself
  };

  task automatic issue(input logic [13:0] word, input logic valid);
    instrValid = valid;
    instr      = word;
    @(negedge clk);
  endtask

  task automatic check(input int req, input logic [7:0] expW, input logic [3:0] expF);
    nChecks++;
    if (wOut !== expW || {zFlag, cFlag, dcFlag, skipReq} !== expF) begin
      nFails++;
      $display("FAIL R%0d: W=%02h ZCDS=%04b expected W=%02h ZCDS=%04b",
               req, wOut, {zFlag, cFlag, dcFlag, skipReq}, expW, expF);
    end
  endtask

  task automatic doReset();
    instrValid = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R2: reset state, then a file entry reads back as zero
    doReset();
    check(2, 8'h00, 4'b0000);
    issue({6'b110000, 8'hA7}, 1'b1);
    issue({6'b001000, 1'b0, 7'h55}, 1'b1);
    check(2, 8'h00, 4'b1000);
    doReset();
    check(2, 8'h00, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][29:16], 1'b1);
      check(int'(VEC[i][3:0]), VEC[i][15:8], VEC[i][7:4]);
    end

    // R12: skip drops and nothing changes while a clear-file word is not valid
    issue({4'b0111, 3'd7, 7'h20}, 1'b1);
    check(9, 8'h08, 4'b0101);
    issue({6'b000001, 1'b1, 7'h20}, 1'b0);
    check(12, 8'h08, 4'b0100);
    issue({6'b001000, 1'b0, 7'h20}, 1'b1);
    check(12, 8'h80, 4'b0100);

    // R1: highest address, neighbour untouched
    issue({6'b110000, 8'hC3}, 1'b1);
    issue({6'b000000, 1'b1, 7'h7F}, 1'b1);
    issue({6'b110000, 8'h00}, 1'b1);
    issue({6'b001000, 1'b0, 7'h7F}, 1'b1);
    check(1, 8'hC3, 4'b0100);
    issue({6'b001000, 1'b0, 7'h7E}, 1'b1);
    check(1, 8'h00, 4'b1100);

    // R3: opcode 000000 with destination 0 changes nothing
    issue(14'h0000, 1'b1);
    check(3, 8'h00, 4'b1100);
    issue(14'h0000, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule